// File: doc/BRIEF.md
# ASID-tagged translation lookaside buffer

This block is a small, fully associative translation cache for an IO memory management unit. Each line holds an address-space identifier (7 bits), a 20-bit virtual page number, a 20-bit physical frame number and three attribute flags: read permission, write permission and nonsecure. Pages are 4 KiB, so the virtual page number is address bits [31:12]. A lookup presents an identifier and a 32-bit virtual address. In the same cycle the block answers with a hit and the translated address, or with a miss.

A miss is handed to an external table walker through a request that the block holds until the walker returns a frame. The returned frame is then written into a line chosen by the replacement logic. A 32-bit command word invalidates lines selectively. It can clear all lines, the lines of one 4 MiB section, or the lines of one 16 KiB group of virtual addresses, and it can optionally be limited to one identifier. A configuration word sets three things: whether lookups continue while a walk is outstanding, how the victim line is chosen, and how many lines are in use.

Top module: `asid_iotlb`

## Requirements
- R1: After reset every line is invalid and no walk is requested. Lookups continue during a walk, pure rotation replacement is selected, and all ENTRIES lines are in use.
- R2: A served lookup whose identifier and page number match a valid line in use raises lk_hit in the same cycle. lk_pa is then {frame, va[11:0]} and lk_rd/lk_wr/lk_ns carry the line's flags. Without a hit, lk_pa and the flags are zero.
- R3: A served lookup that hits nothing raises lk_miss. If no walk is outstanding, walk_req rises at the next clock with walk_asid and walk_vpn = va[31:12]. It stays high with stable values until fill_valid is seen.
- R4: fill_valid while a walk is outstanding ends the walk, so walk_req is low from the next cycle. The line chosen by R6 is written with fill_pfn, fill_rd, fill_wr and fill_ns, and the new translation hits from the next cycle.
- R5: Configuration bit 29 set lets lookups be served while a walk is outstanding. With it clear, such a lookup raises lk_busy and neither lk_hit nor lk_miss.
- R6: Configuration bit 28 set writes fills at a rotation pointer. With it clear, fills go to the lowest-numbered invalid line in use, or to the pointer when no such line exists. The pointer advances by one on every written fill and wraps to 0 at the number of lines in use.
- R7: Configuration bits [5:0] set the number of lines in use, clamped to ENTRIES. A configuration write invalidates every line at or above the new count and moves the pointer to 0 if it lies beyond the count. With a count of 0, fills are discarded.
- R8: Flush command bits [1:0] choose the scope. Value 0 selects all lines. Value 2 selects lines whose page-number bits [19:10] equal command bits [19:10]. Value 3 selects lines whose page-number bits [19:2] equal command bits [19:2]. Value 1 selects nothing.
- R9: Flush command bit 31 further limits the selection to lines whose identifier equals command bits [30:24].
- R10: A flush takes effect at the clock that accepts the command. A lookup in the cycle of the command write still sees the lines as they were.
- R11: A flush whose scope covers the outstanding walk's identifier and page, including one in the same cycle as the fill, causes that walk's fill to be discarded and the pointer to stay put.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word: bit 29 lookups during walk, bit 28 rotation replacement, bits [5:0] lines in use |
| flush_we | input | 1 | Flush command strobe |
| flush_cmd | input | 32 | Flush command word |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup served and hit |
| lk_miss | output | 1 | Lookup served and missed |
| lk_busy | output | 1 | Lookup refused while a walk is outstanding |
| lk_pa | output | 32 | Translated physical address |
| lk_rd | output | 1 | Read permission of the hit line |
| lk_wr | output | 1 | Write permission of the hit line |
| lk_ns | output | 1 | Nonsecure flag of the hit line |
| walk_req | output | 1 | Walk outstanding |
| walk_asid | output | 7 | Identifier of the outstanding walk |
| walk_vpn | output | 20 | Page number of the outstanding walk |
| fill_valid | input | 1 | Walker result strobe |
| fill_pfn | input | 20 | Returned physical frame number |
| fill_rd | input | 1 | Returned read permission |
| fill_wr | input | 1 | Returned write permission |
| fill_ns | input | 1 | Returned nonsecure flag |

## Verification
The bench builds the block with ENTRIES = 4. With four lines, a fifth fill already evicts the oldest line, and the rotation pointer wraps several times within a short run. A requested count of 6 exercises the clamp, and shrinking to 2 lines and back shows that the upper lines are invalidated. The small array also lets one group flush leave exactly one hole, so lowest-invalid placement can be told apart from rotation.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    localparam int ASID_W   = 7;
    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 12;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PFN_W    = 20;
    localparam int PA_W     = PFN_W + PG_SHIFT;
    localparam int WORD_W   = 32;

    // configuration word fields
    localparam int CFG_HUM_BIT = 29;
    localparam int CFG_RR_BIT  = 28;
    localparam int CFG_CNT_W   = 6;

    // flush command fields
    localparam int FL_ASID_EN  = 31;
    localparam int FL_ASID_LSB = 24;

    typedef enum logic [1:0] {
        FL_ALL     = 2'd0,
        FL_NONE    = 2'd1,
        FL_SECTION = 2'd2,
        FL_GROUP   = 2'd3
    } flush_mode_e;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic              rd;
        logic              wr;
        logic              ns;
    } tlb_entry_t;

    // Does a flush command cover a translation with this identifier and page?
    function automatic logic flush_covers(input logic [WORD_W-1:0] cmd,
                                          input logic [ASID_W-1:0] asid,
                                          input logic [VPN_W-1:0]  vpn);
        logic id_ok;
        logic va_ok;
        id_ok = !cmd[FL_ASID_EN] ||
                (cmd[FL_ASID_LSB +: ASID_W] == asid);
        case (cmd[1:0])
            FL_ALL:     va_ok = 1'b1;
            FL_SECTION: va_ok = (vpn[VPN_W-1:10] == cmd[VPN_W-1:10]);
            FL_GROUP:   va_ok = (vpn[VPN_W-1:2] == cmd[VPN_W-1:2]);
            default:    va_ok = 1'b0;
        endcase
        return id_ok && va_ok;
    endfunction

endpackage

// File: rtl/iotlb_match.sv
module iotlb_match
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  tlb_entry_t [ENTRIES-1:0]    ent,
    input  logic [CNT_W-1:0]            active_cnt,
    input  logic [ASID_W-1:0]           lk_asid,
    input  logic [VPN_W-1:0]            lk_vpn,
    input  logic [WORD_W-1:0]           flush_cmd,
    output logic [ENTRIES-1:0]          hit_vec,
    output logic [ENTRIES-1:0]          flush_vec
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_line
        logic in_use;
        assign in_use       = (CNT_W'(g) < active_cnt);
        assign hit_vec[g]   = ent[g].valid && in_use &&
                              (ent[g].asid == lk_asid) &&
                              (ent[g].vpn == lk_vpn);
        assign flush_vec[g] = flush_covers(flush_cmd, ent[g].asid, ent[g].vpn);
    end

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/iotlb_victim.sv
module iotlb_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [IDX_W-1:0]   ptr,
    input  logic [CNT_W-1:0]   active_cnt,
    input  logic               rr_en,
    output logic [IDX_W-1:0]   victim
);

    logic             hole_found;
    logic [IDX_W-1:0] hole_idx;

    always_comb begin
        hole_found = 1'b0;
        hole_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i] && (CNT_W'(i) < active_cnt)) begin
                hole_found = 1'b1;
                hole_idx   = IDX_W'(i);
            end
        end
    end

    assign victim = (!rr_en && hole_found) ? hole_idx : ptr;

    // R6
    victim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_cnt != '0) |-> (CNT_W'(victim) < active_cnt));

endmodule

// File: rtl/asid_iotlb.sv
module asid_iotlb
    import iotlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              flush_we,
    input  logic [31:0]       flush_cmd,
    input  logic              lk_valid,
    input  logic [6:0]        lk_asid,
    input  logic [31:0]       lk_va,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_busy,
    output logic [31:0]       lk_pa,
    output logic              lk_rd,
    output logic              lk_wr,
    output logic              lk_ns,
    output logic              walk_req,
    output logic [6:0]        walk_asid,
    output logic [19:0]       walk_vpn,
    input  logic              fill_valid,
    input  logic [19:0]       fill_pfn,
    input  logic              fill_rd,
    input  logic              fill_wr,
    input  logic              fill_ns
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W = $clog2(ENTRIES + 1);

    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]         ptr;
        logic [CNT_W-1:0]         active;
        logic                     hum;
        logic                     rr;
        logic                     pend;
        logic                     stale;
        logic [ASID_W-1:0]        p_asid;
        logic [VPN_W-1:0]         p_vpn;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] flush_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim;
    logic [VPN_W-1:0]   lk_vpn;
    tlb_entry_t         sel_ent;
    logic               served;
    logic               any_hit;
    logic               kill;
    logic [CNT_W-1:0]   ptr_inc;
    logic [IDX_W-1:0]   ptr_next;
    logic [CNT_W-1:0]   new_cnt;
    logic               cfg_unused;

    assign cfg_unused = ^{cfg_wdata[31:30], cfg_wdata[27:CFG_CNT_W]};
    assign lk_vpn     = lk_va[VA_W-1:PG_SHIFT];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) valid_vec[i] = s_q.ent[i].valid;
    end

    iotlb_match #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .ent        (s_q.ent),
        .active_cnt (s_q.active),
        .lk_asid    (lk_asid),
        .lk_vpn     (lk_vpn),
        .flush_cmd  (flush_cmd),
        .hit_vec    (hit_vec),
        .flush_vec  (flush_vec)
    );

    iotlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .ptr        (s_q.ptr),
        .active_cnt (s_q.active),
        .rr_en      (s_q.rr),
        .victim     (victim)
    );

    // ---------------- lookup answer ----------------
    always_comb begin
        sel_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) sel_ent = s_q.ent[i];
        end
    end

    assign any_hit   = |hit_vec;
    assign served    = lk_valid && (!s_q.pend || s_q.hum);
    assign lk_busy   = lk_valid && s_q.pend && !s_q.hum;
    assign lk_hit    = served && any_hit;
    assign lk_miss   = served && !any_hit;
    assign lk_pa     = lk_hit ? {sel_ent.pfn, lk_va[PG_SHIFT-1:0]} : '0;
    assign lk_rd     = lk_hit && sel_ent.rd;
    assign lk_wr     = lk_hit && sel_ent.wr;
    assign lk_ns     = lk_hit && sel_ent.ns;
    assign walk_req  = s_q.pend;
    assign walk_asid = s_q.p_asid;
    assign walk_vpn  = s_q.p_vpn;

    // ---------------- next state ----------------
    assign kill    = flush_we && s_q.pend &&
                     flush_covers(flush_cmd, s_q.p_asid, s_q.p_vpn);
    assign ptr_inc = CNT_W'(s_q.ptr) + CNT_W'(1);
    assign ptr_next = (ptr_inc >= s_q.active) ? '0 : ptr_inc[IDX_W-1:0];
    assign new_cnt = (int'(cfg_wdata[CFG_CNT_W-1:0]) > ENTRIES) ?
                     CNT_W'(ENTRIES) : CNT_W'(cfg_wdata[CFG_CNT_W-1:0]);

    always_comb begin
        s_d = s_q;

        // selective invalidation
        if (flush_we) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_vec[i]) s_d.ent[i].valid = 1'b0;
            end
        end

        // walker result
        if (fill_valid && s_q.pend) begin
            s_d.pend  = 1'b0;
            s_d.stale = 1'b0;
            if (!s_q.stale && !kill && (s_q.active != '0)) begin
                s_d.ent[victim].valid = 1'b1;
                s_d.ent[victim].asid  = s_q.p_asid;
                s_d.ent[victim].vpn   = s_q.p_vpn;
                s_d.ent[victim].pfn   = fill_pfn;
                s_d.ent[victim].rd    = fill_rd;
                s_d.ent[victim].wr    = fill_wr;
                s_d.ent[victim].ns    = fill_ns;
                s_d.ptr               = ptr_next;
            end
        end else if (kill) begin
            s_d.stale = 1'b1;
        end

        // launch a walk
        if (lk_miss && !s_q.pend) begin
            s_d.pend   = 1'b1;
            s_d.stale  = 1'b0;
            s_d.p_asid = lk_asid;
            s_d.p_vpn  = lk_vpn;
        end

        // configuration
        if (cfg_we) begin
            s_d.hum    = cfg_wdata[CFG_HUM_BIT];
            s_d.rr     = cfg_wdata[CFG_RR_BIT];
            s_d.active = new_cnt;
            for (int i = 0; i < ENTRIES; i++) begin
                if (CNT_W'(i) >= new_cnt) s_d.ent[i].valid = 1'b0;
            end
            if (CNT_W'(s_d.ptr) >= new_cnt) s_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.active <= CNT_W'(ENTRIES);
            s_q.hum    <= 1'b1;
            s_q.rr     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // ---------------- checks ----------------
    // R2
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=> (walk_req && $stable(walk_asid) && $stable(walk_vpn)));

    // R4
    walk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid && !lk_valid) |=> !walk_req);

    // R5
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !s_q.hum) |-> (!lk_hit && !lk_miss));

    // R10
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_we && flush_cmd[1:0] == 2'd0 && !flush_cmd[31]) |=> !lk_hit);

    // R7
    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        beyond_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (CNT_W'(g) >= s_q.active) |-> !s_q.ent[g].valid);
    end

endmodule

// File: tb/asid_iotlb_bench.sv
module asid_iotlb_bench;

    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0;
    logic [31:0] cfg_wdata = 0;
    logic        flush_we = 0;
    logic [31:0] flush_cmd = 0;
    logic        lk_valid = 0;
    logic [6:0]  lk_asid = 0;
    logic [31:0] lk_va = 0;
    logic        lk_hit, lk_miss, lk_busy, lk_rd, lk_wr, lk_ns, walk_req;
    logic [31:0] lk_pa;
    logic [6:0]  walk_asid;
    logic [19:0] walk_vpn;
    logic        fill_valid = 0;
    logic [19:0] fill_pfn = 0;
    logic        fill_rd = 0, fill_wr = 0, fill_ns = 0;

    always #2 clk = ~clk;

    asid_iotlb #(.ENTRIES(NE)) u_asid_iotlb (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .flush_we(flush_we), .flush_cmd(flush_cmd), .lk_valid(lk_valid),
        .lk_asid(lk_asid), .lk_va(lk_va), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_busy(lk_busy), .lk_pa(lk_pa), .lk_rd(lk_rd), .lk_wr(lk_wr),
        .lk_ns(lk_ns), .walk_req(walk_req), .walk_asid(walk_asid),
        .walk_vpn(walk_vpn), .fill_valid(fill_valid), .fill_pfn(fill_pfn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_ns(fill_ns)
    );

    // ---------------- reference model ----------------
    bit        m_v[NE];
    bit [6:0]  m_asid[NE];
    bit [19:0] m_vpn[NE];
    bit [19:0] m_pfn[NE];
    bit        m_rd[NE], m_wr[NE], m_ns[NE];
    int        m_ptr, m_act;
    bit        m_hum, m_rr, m_pend, m_stale;
    bit [6:0]  m_pa_asid;
    bit [19:0] m_pa_vpn;

    int    vectors = 0;
    int    miscompares = 0;
    bit    finished = 0;
    string cur_req = "R1";

    function automatic bit m_covers(bit [31:0] cmd, bit [6:0] a, bit [19:0] v);
        bit aok;
        aok = !cmd[31] || (cmd[30:24] == a);
        case (cmd[1:0])
            2'd0:    return aok;
            2'd2:    return aok && (v[19:10] == cmd[19:10]);
            2'd3:    return aok && (v[19:2] == cmd[19:2]);
            default: return 0;
        endcase
    endfunction

    function automatic int m_find();
        for (int i = 0; i < NE; i++)
            if (i < m_act && m_v[i] && m_asid[i] == lk_asid && m_vpn[i] == lk_va[31:12])
                return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        m_ptr = 0; m_act = NE; m_hum = 1; m_rr = 1; m_pend = 0; m_stale = 0;
        m_pa_asid = 0; m_pa_vpn = 0;
    endtask

    task automatic model_edge();
        bit served, miss, kill, was_pend;
        int idx, vic, cnt;
        was_pend = m_pend;
        served = lk_valid && (!m_pend || m_hum);
        idx    = m_find();
        miss   = served && idx < 0;
        vic    = m_ptr;
        if (!m_rr)
            for (int i = NE - 1; i >= 0; i--) if (i < m_act && !m_v[i]) vic = i;
        kill = flush_we && m_pend && m_covers(flush_cmd, m_pa_asid, m_pa_vpn);
        if (flush_we)
            for (int i = 0; i < NE; i++) if (m_covers(flush_cmd, m_asid[i], m_vpn[i])) m_v[i] = 0;
        if (fill_valid && m_pend) begin
            if (!m_stale && !kill && m_act > 0) begin
                m_v[vic] = 1; m_asid[vic] = m_pa_asid; m_vpn[vic] = m_pa_vpn;
                m_pfn[vic] = fill_pfn; m_rd[vic] = fill_rd; m_wr[vic] = fill_wr; m_ns[vic] = fill_ns;
                m_ptr = (m_ptr + 1 >= m_act) ? 0 : m_ptr + 1;
            end
            m_pend = 0; m_stale = 0;
        end else if (kill) m_stale = 1;
        if (miss && !was_pend) begin
            m_pend = 1; m_stale = 0; m_pa_asid = lk_asid; m_pa_vpn = lk_va[31:12];
        end
        if (cfg_we) begin
            m_hum = cfg_wdata[29]; m_rr = cfg_wdata[28];
            cnt = int'(cfg_wdata[5:0]);
            m_act = (cnt > NE) ? NE : cnt;
            for (int i = 0; i < NE; i++) if (i >= m_act) m_v[i] = 0;
            if (m_ptr >= m_act) m_ptr = 0;
        end
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit served; int idx;
        served = lk_valid && (!m_pend || m_hum);
        idx    = m_find();
        chk("lk_hit",  32'(lk_hit),  32'(served && idx >= 0));
        chk("lk_miss", 32'(lk_miss), 32'(served && idx < 0));
        chk("lk_busy", 32'(lk_busy), 32'(lk_valid && m_pend && !m_hum));
        if (served && idx >= 0) begin
            chk("lk_pa", lk_pa, {m_pfn[idx], lk_va[11:0]});
            chk("lk_attr", 32'({lk_rd, lk_wr, lk_ns}), 32'({m_rd[idx], m_wr[idx], m_ns[idx]}));
        end else begin
            chk("lk_pa", lk_pa, 32'h0);
            chk("lk_attr", 32'({lk_rd, lk_wr, lk_ns}), 32'h0);
        end
        chk("walk_req", 32'(walk_req), 32'(m_pend));
        if (m_pend) begin
            chk("walk_asid", 32'(walk_asid), 32'(m_pa_asid));
            chk("walk_vpn",  32'(walk_vpn),  32'(m_pa_vpn));
        end
    endtask

    // inputs are driven after a falling edge; compared 1 ns later
    task automatic step();
        #1 compare();
        @(posedge clk);
        if (rst_n) model_edge();
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; flush_we = 0; cfg_we = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic lookup(bit [6:0] a, bit [31:0] va);
        lk_valid = 1; lk_asid = a; lk_va = va; step();
    endtask

    task automatic fill(bit [19:0] pfn, bit r, bit w, bit n);
        fill_valid = 1; fill_pfn = pfn; fill_rd = r; fill_wr = w; fill_ns = n; step();
    endtask

    task automatic map(bit [6:0] a, bit [31:0] va, bit [19:0] pfn, bit r, bit w, bit n);
        lookup(a, va); idle(1); fill(pfn, r, w, n); lookup(a, va);
    endtask

    task automatic flush(bit [31:0] cmd);
        flush_we = 1; flush_cmd = cmd; step();
    endtask

    task automatic cfg(bit hum, bit rr, int cnt);
        cfg_we = 1; cfg_wdata = 0; cfg_wdata[29] = hum; cfg_wdata[28] = rr;
        cfg_wdata[5:0] = 6'(cnt); step();
    endtask

    function automatic bit [31:0] sec_cmd(bit [31:0] va, bit aen, bit [6:0] a);
        return ((va & 32'hffc0_0000) >> 12) | 32'd2 | (32'(aen) << 31) | (32'(a) << 24);
    endfunction

    function automatic bit [31:0] grp_cmd(bit [31:0] va, bit aen, bit [6:0] a);
        return ((va & 32'hffff_c000) >> 12) | 32'd3 | (32'(aen) << 31) | (32'(a) << 24);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, lookup misses
        cur_req = "R1"; idle(2);
        lookup(7'd9, 32'h0000_0000); idle(1); fill(20'h00001, 1, 0, 0);
        // R3 / R4 / R2: miss, held walk, fill, hit
        cur_req = "R3"; lookup(7'd1, 32'h0040_1234); idle(3);
        cur_req = "R4"; fill(20'h12345, 1, 1, 0);
        cur_req = "R2"; lookup(7'd1, 32'h0040_1FFF); lookup(7'd2, 32'h0040_1234);
        // R5: hit under miss enabled then disabled
        cur_req = "R5"; lookup(7'd2, 32'h0080_0000); lookup(7'd1, 32'h0040_1ABC);
        lookup(7'd3, 32'h0111_0000); fill(20'h00800, 0, 1, 1);
        cfg(0, 1, NE); lookup(7'd3, 32'h0100_0000); lookup(7'd1, 32'h0040_1000);
        idle(1); fill(20'h01000, 1, 1, 1); lookup(7'd1, 32'h0040_1000);
        cfg(1, 1, NE);
        // R6: rotation eviction and wrap
        cur_req = "R6";
        map(7'd4, 32'h0200_0000, 20'h02000, 1, 0, 1);
        map(7'd5, 32'h0300_0000, 20'h03000, 0, 0, 1);
        map(7'd6, 32'h0400_0000, 20'h04000, 1, 1, 1);
        lookup(7'd9, 32'h0000_0000); lookup(7'd1, 32'h0040_1000);
        idle(1); fill(20'h0AAAA, 1, 0, 0);
        cfg(1, 0, NE);
        flush(grp_cmd(32'h0300_0000, 1, 7'd5));
        map(7'd7, 32'h0500_0000, 20'h05000, 1, 1, 0);
        lookup(7'd6, 32'h0400_0000); lookup(7'd4, 32'h0200_0000);
        map(7'd8, 32'h0600_0000, 20'h06000, 0, 1, 0);
        lookup(7'd7, 32'h0500_0000);
        // R7: active line count
        cur_req = "R7"; cfg(1, 1, 2);
        lookup(7'd4, 32'h0200_0000); lookup(7'd7, 32'h0500_0000); idle(1); fill(20'h0B000, 0, 0, 0);
        cfg(1, 1, 6);
        map(7'd10, 32'h0700_0000, 20'h07000, 1, 1, 1);
        map(7'd11, 32'h0800_0000, 20'h08000, 1, 0, 1);
        cfg(1, 1, 0); map(7'd12, 32'h0900_0000, 20'h09000, 1, 1, 1);
        cfg(1, 1, NE);
        // R8: flush scopes
        cur_req = "R8";
        map(7'd20, 32'h1040_0000, 20'h11000, 1, 1, 0);
        map(7'd21, 32'h107F_F000, 20'h12000, 1, 1, 0);
        map(7'd22, 32'h1080_0000, 20'h13000, 1, 1, 0);
        map(7'd23, 32'h1080_4000, 20'h14000, 1, 1, 0);
        flush(32'h0000_0001);
        lookup(7'd20, 32'h1040_0000);
        flush(sec_cmd(32'h1040_0000, 0, 7'd0));
        lookup(7'd20, 32'h1040_0000); idle(1); fill(20'h11000, 1, 1, 0);
        lookup(7'd21, 32'h107F_F000); idle(1); fill(20'h12000, 1, 1, 0);
        lookup(7'd22, 32'h1080_0000); lookup(7'd23, 32'h1080_4000);
        flush(grp_cmd(32'h1080_0000, 0, 7'd0));
        lookup(7'd22, 32'h1080_0000); idle(1); fill(20'h13000, 0, 0, 0);
        lookup(7'd23, 32'h1080_4000);
        // R9: identifier-limited flushes
        cur_req = "R9";
        flush(32'h8000_0000 | (32'd99 << 24));
        lookup(7'd23, 32'h1080_4000);
        flush(32'h8000_0000 | (32'd23 << 24));
        lookup(7'd23, 32'h1080_4000); idle(1); fill(20'h14000, 1, 0, 1);
        flush(sec_cmd(32'h1040_0000, 1, 7'd21));
        lookup(7'd20, 32'h1040_0000); lookup(7'd21, 32'h107F_F000); idle(1); fill(20'h15000, 1, 1, 1);
        // R10: flush in the same cycle as a lookup
        cur_req = "R10";
        lk_valid = 1; lk_asid = 7'd20; lk_va = 32'h1040_0010;
        flush_we = 1; flush_cmd = 32'h0; step();
        lookup(7'd20, 32'h1040_0010); idle(1); fill(20'h16000, 1, 1, 1);
        lookup(7'd20, 32'h1040_0010);
        // R11: stale refills
        cur_req = "R11";
        lookup(7'd30, 32'h0A00_0000); idle(1);
        flush(grp_cmd(32'h0A00_0000, 1, 7'd30)); idle(1); fill(20'h0DEAD, 1, 1, 1);
        lookup(7'd30, 32'h0A00_0000);
        flush_we = 1; flush_cmd = sec_cmd(32'h0A00_0000, 0, 7'd0);
        fill_valid = 1; fill_pfn = 20'h0BEEF; step();
        lookup(7'd30, 32'h0A00_0000);
        flush(32'h8000_0000 | (32'd31 << 24)); fill(20'h0CAFE, 0, 1, 0);
        lookup(7'd30, 32'h0A00_0123); lookup(7'd20, 32'h1040_0010);
        idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule